// File: doc/BRIEF.md
# Three-Tier Vectored Interrupt Controller

This block gathers level-sensitive request lines, one from each peripheral, and sends each one to a processor through one of three classes: fast, vectored normal, or non-vectored normal. Software sets which class each line belongs to and can change it at run time. Every enabled fast-class request feeds a single fast-interrupt output. Every enabled request of the normal class, vectored or not, feeds the normal-interrupt output.

Sixteen ranked vector slots each name one source line and hold a service address. Slot 0 ranks highest. A read of the vector register returns the address of the best-ranked slot whose source is an active, enabled normal-class request. When no slot matches, the read returns a shared default address. Three separate status words show the raw lines, the masked fast requesters and the masked normal requesters, so a shared handler can find the source that called it.

Configuration and status use a plain synchronous word port. A write takes effect at the clock edge on which it is presented. A read returns its data on the cycle after the strobe and holds that data until the next strobe.

Top module: `irqc_top`

## Requirements
- R1: After reset, `fiq_o`, `irq_o` and `reg_rdata` are 0. The enable mask, class select, default address and every slot are cleared, so every readable word reads 0 except the raw word (offset 0x00).
- R2: A source whose bit in the enable word (offset 0x01) is 0 has no effect on `fiq_o`, `irq_o`, the fast status, the normal status or the vector read. The raw word (offset 0x00) still shows its line.
- R3: In the class word (offset 0x02), bit value 1 selects the fast class. `fiq_o` is 1 on the cycle after any enabled fast-class line is high, and it is the OR of all such lines.
- R4: `irq_o` is 1 on the cycle after any enabled line with a class bit of 0 is high, whether or not a slot names that line.
- R5: The fast status word (offset 0x03) reads `req & enable & class`. The normal status word (offset 0x04) reads `req & enable & ~class`.
- R6: Slot control words sit at offset 0x40+s. Bit 5 is the slot enable and bits 4:0 are the source number. Slot address words sit at offset 0x80+s. A slot matches only when its enable bit is 1 and its source is an active, enabled, normal-class line.
- R7: When several slots match, the vector read (offset 0x05) returns the address of the lowest-numbered matching slot.
- R8: When no slot matches, the vector read returns the default address word (offset 0x06). This includes the case of a slot that names a fast-class source.
- R9: Read data is captured at the edge where `reg_rd` is 1 and is held unchanged until the next read strobe. The vector value is the one in force at the strobe edge.
- R10: A change to the enable word or the class word moves a request between outputs starting with the first output update after the write edge.
- R11: Writes to the read-only offsets 0x00, 0x03, 0x04 and 0x05 change no configuration and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 32 | Level request lines, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| fiq_o | output | 1 | Fast interrupt to the processor |
| irq_o | output | 1 | Normal interrupt to the processor |

## Verification
`fiq_o` and `irq_o` are registered once. They are due one edge after a request line changes and one edge after the write edge that changes the enable or class word. Read data is due at the edge that samples `reg_rd`. The bench drives every input at a falling edge. For each result it waits exactly the edges counted above and samples at the next falling edge, away from the edge that updates the outputs. Vector results are compared against an address the bench works out from its own copy of the programmed slots, scanning from the highest slot down.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_RAW      = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ENABLE   = 8'h01;
  localparam logic [ADDR_W-1:0] OFS_CLASS    = 8'h02;
  localparam logic [ADDR_W-1:0] OFS_FAST     = 8'h03;
  localparam logic [ADDR_W-1:0] OFS_NORM     = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_VECTOR   = 8'h05;
  localparam logic [ADDR_W-1:0] OFS_DEFAULT  = 8'h06;
  localparam logic [ADDR_W-1:0] OFS_SLOT_CTL = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_SLOT_ADR = 8'h80;

  // true when addr lies in [base, base+count)
  function automatic logic in_window(logic [ADDR_W-1:0] addr,
                                     logic [ADDR_W-1:0] base,
                                     int unsigned count);
    return (int'(addr) >= int'(base)) && (int'(addr) < int'(base) + int'(count));
  endfunction
endpackage

// File: rtl/irqc_classify.sv
module irqc_classify #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] en_mask,
  input  logic [N_SRC-1:0] class_mask,
  output logic [N_SRC-1:0] fast_stat,
  output logic [N_SRC-1:0] norm_stat
);
  function automatic logic [N_SRC-1:0] gate(logic [N_SRC-1:0] r,
                                            logic [N_SRC-1:0] e,
                                            logic [N_SRC-1:0] c,
                                            logic want_fast);
    return r & e & (want_fast ? c : ~c);
  endfunction

  assign fast_stat = gate(req, en_mask, class_mask, 1'b1);
  assign norm_stat = gate(req, en_mask, class_mask, 1'b0);

  // R5: a source is never reported in both classes
  assert_class_disjoint_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_stat & norm_stat) == '0);
  // R2: a masked source never shows in either status word
  assert_mask_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((fast_stat | norm_stat) & ~en_mask) == '0);
endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned SRC_W  = $clog2(N_SRC)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DW-1:0]                 reg_wdata,
  output logic [N_SRC-1:0]              en_mask,
  output logic [N_SRC-1:0]              class_mask,
  output logic [N_SLOT-1:0]             slot_en,
  output logic [N_SLOT-1:0][SRC_W-1:0]  slot_src,
  output logic [N_SLOT-1:0][DW-1:0]     slot_adr,
  output logic [DW-1:0]                 def_adr
);
  logic wr_ro;
  assign wr_ro = reg_wr && (reg_addr == OFS_RAW || reg_addr == OFS_FAST ||
                            reg_addr == OFS_NORM || reg_addr == OFS_VECTOR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask    <= '0;
      class_mask <= '0;
      def_adr    <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_ENABLE)  en_mask    <= reg_wdata[N_SRC-1:0];
      if (reg_addr == OFS_CLASS)   class_mask <= reg_wdata[N_SRC-1:0];
      if (reg_addr == OFS_DEFAULT) def_adr    <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_en  <= '0;
      slot_src <= '0;
      slot_adr <= '0;
    end else if (reg_wr) begin
      for (int s = 0; s < int'(N_SLOT); s++) begin
        if (reg_addr == ADDR_W'(int'(OFS_SLOT_CTL) + s)) begin
          slot_en[s]  <= reg_wdata[SRC_W];
          slot_src[s] <= reg_wdata[SRC_W-1:0];
        end
        if (reg_addr == ADDR_W'(int'(OFS_SLOT_ADR) + s))
          slot_adr[s] <= reg_wdata;
      end
    end
  end

  // R11: a write to a status offset leaves the configuration alone
  assert_ro_write_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ro |=> ($stable(en_mask) && $stable(class_mask) && $stable(def_adr) &&
               $stable(slot_en) && $stable(slot_adr)));
endmodule

// File: rtl/irqc_vec_arb.sv
module irqc_vec_arb #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned SRC_W  = $clog2(N_SRC)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SRC-1:0]              norm_stat,
  input  logic [N_SLOT-1:0]             slot_en,
  input  logic [N_SLOT-1:0][SRC_W-1:0]  slot_src,
  input  logic [N_SLOT-1:0][DW-1:0]     slot_adr,
  input  logic [DW-1:0]                 def_adr,
  output logic                          any_hit,
  output logic [DW-1:0]                 vec_addr
);
  logic [N_SLOT-1:0] hit;
  logic [N_SLOT-1:0] grant;
  logic [DW-1:0]     won_adr;

  // isolate the least significant set bit
  function automatic logic [N_SLOT-1:0] lowest_one(logic [N_SLOT-1:0] v);
    return v & (~v + N_SLOT'(1));
  endfunction

  for (genvar s = 0; s < int'(N_SLOT); s++) begin : g_hit
    assign hit[s] = slot_en[s] & norm_stat[slot_src[s]];
  end

  assign grant = lowest_one(hit);

  always_comb begin
    won_adr = '0;
    for (int s = 0; s < int'(N_SLOT); s++)
      if (grant[s]) won_adr = won_adr | slot_adr[s];
  end

  assign any_hit  = |hit;
  assign vec_addr = any_hit ? won_adr : def_adr;

  // R7: at most one slot wins
  assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R7: the winner is a matching slot and a match always yields a winner
  assert_grant_from_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~hit) == '0) && (any_hit == (grant != '0)));
  // R7: slot 0 beats everyone when it matches
  assert_slot0_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |-> (vec_addr == slot_adr[0]));
  // R6: a disabled slot never wins
  assert_off_slot_loses_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~slot_en) == '0);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int unsigned SRC_W  = $clog2(N_SRC);
  localparam int unsigned SLOT_W = $clog2(N_SLOT);

  logic [N_SRC-1:0]             en_mask, class_mask, fast_stat, norm_stat;
  logic [N_SLOT-1:0]            slot_en;
  logic [N_SLOT-1:0][SRC_W-1:0] slot_src;
  logic [N_SLOT-1:0][DW-1:0]    slot_adr;
  logic [DW-1:0]                def_adr, vec_addr, rd_word;
  logic                         any_hit, fast_any, norm_any;
  logic [SLOT_W-1:0]            ctl_idx, adr_idx;

  irqc_cfg #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DW(DW), .SRC_W(SRC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .en_mask(en_mask), .class_mask(class_mask),
    .slot_en(slot_en), .slot_src(slot_src), .slot_adr(slot_adr),
    .def_adr(def_adr)
  );

  irqc_classify #(.N_SRC(N_SRC)) u_cls (
    .clk(clk), .rst_n(rst_n), .req(req_i), .en_mask(en_mask),
    .class_mask(class_mask), .fast_stat(fast_stat), .norm_stat(norm_stat)
  );

  irqc_vec_arb #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DW(DW), .SRC_W(SRC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .norm_stat(norm_stat), .slot_en(slot_en),
    .slot_src(slot_src), .slot_adr(slot_adr), .def_adr(def_adr),
    .any_hit(any_hit), .vec_addr(vec_addr)
  );

  assign fast_any = |fast_stat;
  assign norm_any = |norm_stat;
  assign ctl_idx  = SLOT_W'(reg_addr - OFS_SLOT_CTL);
  assign adr_idx  = SLOT_W'(reg_addr - OFS_SLOT_ADR);

  always_comb begin
    rd_word = '0;
    if (reg_addr == OFS_RAW)          rd_word = DW'(req_i);
    else if (reg_addr == OFS_ENABLE)  rd_word = DW'(en_mask);
    else if (reg_addr == OFS_CLASS)   rd_word = DW'(class_mask);
    else if (reg_addr == OFS_FAST)    rd_word = DW'(fast_stat);
    else if (reg_addr == OFS_NORM)    rd_word = DW'(norm_stat);
    else if (reg_addr == OFS_VECTOR)  rd_word = vec_addr;
    else if (reg_addr == OFS_DEFAULT) rd_word = def_adr;
    else if (in_window(reg_addr, OFS_SLOT_CTL, N_SLOT))
      rd_word = DW'({slot_en[ctl_idx], slot_src[ctl_idx]});
    else if (in_window(reg_addr, OFS_SLOT_ADR, N_SLOT))
      rd_word = slot_adr[adr_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fiq_o     <= 1'b0;
      irq_o     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      fiq_o <= fast_any;
      irq_o <= norm_any;
      if (reg_rd) reg_rdata <= rd_word;
    end
  end

  // R3: the fast output follows any enabled fast-class request one cycle later
  assert_fast_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fast_any |=> fiq_o);
  assert_fast_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(fast_any));
  // R4: the normal output follows any enabled normal-class request
  assert_norm_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    norm_any |=> irq_o);
  assert_norm_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(norm_any));
  // R8: with no matching slot the vector read gives the default address
  assert_default_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_VECTOR && !any_hit) |=> (reg_rdata == $past(def_adr)));
  // R9: read data only moves on a read strobe
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
  import irqc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_i = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fiq_o, irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] sh_en = '0, sh_cls = '0, sh_def = '0;
  logic        sh_sen [16];
  logic [4:0]  sh_src [16];
  logic [31:0] sh_adr [16];

  always #2 clk = ~clk;

  irqc_top u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_req(logic [31:0] r);
    @(negedge clk);
    req_i = r;
    @(negedge clk);
  endtask

  task automatic prog_slot(int s, logic on, logic [4:0] src, logic [31:0] adr);
    wr(8'(int'(OFS_SLOT_CTL) + s), {26'd0, on, src});
    wr(8'(int'(OFS_SLOT_ADR) + s), adr);
    sh_sen[s] = on; sh_src[s] = src; sh_adr[s] = adr;
  endtask

  function automatic logic [31:0] model_vec(logic [31:0] r);
    logic [31:0] act;
    logic [31:0] res;
    act = r & sh_en & ~sh_cls;
    res = sh_def;
    for (int s = 15; s >= 0; s--)
      if (sh_sen[s] && act[sh_src[s]]) res = sh_adr[s];
    return res;
  endfunction

  task automatic check_outputs(string tag);
    logic [31:0] v;
    chk({tag, " fiq"}, {31'd0, fiq_o}, {31'd0, |(req_i & sh_en & sh_cls)});
    chk({tag, " irq"}, {31'd0, irq_o}, {31'd0, |(req_i & sh_en & ~sh_cls)});
    rd(OFS_VECTOR, v);
    chk({tag, " vector"}, v, model_vec(req_i));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 fiq after reset", {31'd0, fiq_o}, 32'd0);
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R1 rdata after reset", reg_rdata, 32'd0);
    rd(OFS_ENABLE, v);   chk("R1 enable word", v, 32'd0);
    rd(OFS_VECTOR, v);   chk("R1 vector word", v, 32'd0);
    rd(8'h47, v);        chk("R1 slot7 control", v, 32'd0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    set_req(32'hFFFF_FFFF);
    check_outputs("R2 all masked");
    rd(OFS_RAW, v);  chk("R2 raw visible", v, 32'hFFFF_FFFF);
    rd(OFS_NORM, v); chk("R2 normal status masked", v, 32'd0);
    set_req(32'd0);
  endtask

  task automatic t_classes();
    logic [31:0] v;
    wr(OFS_ENABLE, 32'hFFFF_FFFF); sh_en = 32'hFFFF_FFFF;
    wr(OFS_CLASS, 32'h0000_0011);  sh_cls = 32'h0000_0011;
    set_req(32'h0000_0010);
    chk("R3 single fast", {31'd0, fiq_o}, 32'd1);
    chk("R4 no normal", {31'd0, irq_o}, 32'd0);
    rd(OFS_FAST, v); chk("R5 fast status", v, 32'h0000_0010);
    set_req(32'h0000_0011);
    chk("R3 fast OR", {31'd0, fiq_o}, 32'd1);
    set_req(32'h0200_0100);
    chk("R3 fast clear", {31'd0, fiq_o}, 32'd0);
    chk("R4 non-vectored raises irq", {31'd0, irq_o}, 32'd1);
    rd(OFS_NORM, v); chk("R5 normal status", v, 32'h0200_0100);
    rd(OFS_FAST, v); chk("R5 fast status empty", v, 32'd0);
    set_req(32'd0);
  endtask

  task automatic t_slots();
    logic [31:0] v;
    wr(OFS_DEFAULT, 32'h0000_D0D0); sh_def = 32'h0000_D0D0;
    prog_slot(2, 1'b1, 5'd12, 32'h0000_2000);
    prog_slot(5, 1'b1, 5'd7,  32'h0000_5000);
    prog_slot(0, 1'b0, 5'd20, 32'h0000_DEAD);
    prog_slot(1, 1'b1, 5'd4,  32'h0000_1000);
    rd(8'h45, v); chk("R6 slot5 control readback", v, 32'h0000_0027);
    set_req(32'h0000_0080);
    check_outputs("R6 slot5 match");
    rd(OFS_VECTOR, v); chk("R6 slot5 address", v, 32'h0000_5000);
    set_req(32'h0000_1080);
    rd(OFS_VECTOR, v); chk("R7 lower slot wins", v, 32'h0000_2000);
    set_req(32'h0010_0000);
    rd(OFS_VECTOR, v); chk("R6 disabled slot ignored", v, 32'h0000_D0D0);
    chk("R4 irq without slot", {31'd0, irq_o}, 32'd1);
    set_req(32'h0000_0010);
    rd(OFS_VECTOR, v); chk("R8 fast source not vectored", v, 32'h0000_D0D0);
    check_outputs("R8 fast in slot");
    set_req(32'h0000_0000);
    rd(OFS_VECTOR, v); chk("R8 idle default", v, 32'h0000_D0D0);
  endtask

  task automatic t_reclass();
    logic [31:0] v;
    set_req(32'h0000_0080);
    wr(OFS_CLASS, 32'h0000_0091); sh_cls = 32'h0000_0091;
    @(negedge clk);
    chk("R10 moved to fast", {31'd0, fiq_o}, 32'd1);
    chk("R10 left normal", {31'd0, irq_o}, 32'd0);
    rd(OFS_VECTOR, v); chk("R10 vector falls back", v, 32'h0000_D0D0);
    wr(OFS_ENABLE, 32'hFFFF_FF7F); sh_en = 32'hFFFF_FF7F;
    @(negedge clk);
    chk("R10 mask drops fast", {31'd0, fiq_o}, 32'd0);
    wr(OFS_CLASS, 32'h0000_0011); sh_cls = 32'h0000_0011;
    wr(OFS_ENABLE, 32'hFFFF_FFFF); sh_en = 32'hFFFF_FFFF;
    @(negedge clk);
    check_outputs("R10 restored");
  endtask

  task automatic t_ro_writes();
    logic [31:0] v;
    set_req(32'h0000_0080);
    wr(OFS_FAST, 32'hFFFF_FFFF);
    wr(OFS_VECTOR, 32'h1234_5678);
    wr(OFS_RAW, 32'hFFFF_FFFF);
    wr(OFS_NORM, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R11 fiq unchanged", {31'd0, fiq_o}, 32'd0);
    rd(OFS_CLASS, v);  chk("R11 class intact", v, 32'h0000_0011);
    rd(OFS_VECTOR, v); chk("R11 vector intact", v, 32'h0000_5000);
    rd(OFS_RAW, v);    chk("R11 raw intact", v, 32'h0000_0080);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    rd(OFS_VECTOR, v); chk("R9 captured", v, 32'h0000_5000);
    set_req(32'h0000_1000);
    repeat (3) @(negedge clk);
    chk("R9 held without strobe", reg_rdata, 32'h0000_5000);
    rd(OFS_VECTOR, v); chk("R9 new strobe", v, 32'h0000_2000);
    set_req(32'd0);
  endtask

  initial begin
    for (int s = 0; s < 16; s++) begin
      sh_sen[s] = 1'b0; sh_src[s] = '0; sh_adr[s] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_classes();
    t_slots();
    t_reclass();
    t_ro_writes();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule